// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps a DRAM that counts its own rows in refresh, and it brings the DRAM up after power is applied. Leaving reset, it waits out a timed pause. It then runs a fixed number of warm-up refresh cycles, and only after that does it raise `ready` so that normal traffic may start. From then on, a free-running interval counter adds one refresh to a small backlog at a steady rate. Each time the access arbiter grants the bus, one backlog entry is served.

A refresh cycle drops the column strobes first, then drops the row strobe, and releases the column strobes a set time later. The row strobe is held low for its minimum width and then held high for its precharge time. No address is needed. Every interval is a parameter in nanoseconds, converted to clock cycles from the clock period.

During refresh the write enable stays high and the data bus is not driven. If the backlog is already full when a new refresh falls due, a sticky overflow flag is set.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied, `ras_n`, `ucas_n` and `lcas_n` are high, `ready`, `ref_req` and `pend_ovf` are low, and `busy` is high.
- R2: For ceil(200 us / clock period) cycles after reset is released, `ready` and `ref_req` stay low and no strobe moves.
- R3: `ready` rises only after exactly 8 refresh cycles have completed since reset. Once high, it stays high.
- R4: In each refresh cycle, both column strobes fall together ceil(5 ns / period) cycles before the row strobe falls. They stay low for ceil(10 ns / period) cycles after the row strobe falls, then return high.
- R5: The row strobe stays low for max(ceil(50 ns/T), ceil(90 ns/T) − ceil(30 ns/T)) cycles. It is then high for at least ceil(30 ns/T) cycles before the next refresh starts.
- R6: A refresh cycle starts, with the column strobes falling, only in the cycle after one in which both `ref_req` and `ref_gnt` were high. While `ref_gnt` is low, no refresh starts and `ref_req` stays high.
- R7: Once `ready` is high, one refresh falls due every floor(15.6 us / period) cycles.
- R8: Refreshes that fall due while no grant arrives are kept, up to 4. Each kept refresh is served by one refresh cycle, back to back, when grants arrive.
- R9: `pend_ovf` is set when a refresh falls due while 4 are already kept and none completes in that cycle. It then stays set until reset.
- R10: `we_n` is always high and `dq_oe` (data bus drive enable, active high) is always low.
- R11: `busy` is high during the power-up pause and from the first cycle of a refresh to the end of its precharge. `ref_req` is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Bus grant from the access arbiter |
| ref_req | output | 1 | Request for the bus to run a refresh |
| busy | output | 1 | Pause or refresh cycle in progress |
| ready | output | 1 | Power-up sequence complete; traffic allowed |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper column strobe, active low |
| lcas_n | output | 1 | Lower column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| dq_oe | output | 1 | Data bus drive enable, held low |
| pend_ovf | output | 1 | Sticky backlog overflow flag |

## Verification
A behavioural model of pause, backlog and strobe timing is compared with the design on every cycle. The grant patterns used are:
- A grant held low through the pause and past its end. This separates a request that waits correctly from one that starts unbidden.
- A grant held high, so each refresh is served the moment it falls due. This exposes the interval length and the back-to-back warm-up cycles.
- A grant withheld for several intervals and then given. This shows whether the backlog is counted and drained one cycle per entry.
- A grant toggled every cycle, which tests that a refresh starts only on a sampled grant.
- A long withholding that pushes the backlog past its limit, which separates saturation and the sticky flag from wrap-around.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_NS         = 20,
  parameter int PAUSE_NS       = 200000,
  parameter int REFI_NS        = 15600,
  parameter int INIT_REFRESHES = 8,
  parameter int CSR_NS         = 5,
  parameter int CHR_NS         = 10,
  parameter int RAS_NS         = 50,
  parameter int RP_NS          = 30,
  parameter int RC_NS          = 90,
  parameter int BACKLOG_MAX    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic busy,
  output logic ready,
  output logic ras_n,
  output logic ucas_n,
  output logic lcas_n,
  output logic we_n,
  output logic dq_oe,
  output logic pend_ovf
);
  localparam int PAUSE_CYC = (PAUSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int REFI_CYC  = REFI_NS / CLK_NS;
  localparam int CSR_C0    = (CSR_NS + CLK_NS - 1) / CLK_NS;
  localparam int CHR_C0    = (CHR_NS + CLK_NS - 1) / CLK_NS;
  localparam int RP_C0     = (RP_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAS_C0    = (RAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int RC_C      = (RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int CSR_CYC   = CSR_C0 < 1 ? 1 : CSR_C0;
  localparam int CHR_CYC   = CHR_C0 < 1 ? 1 : CHR_C0;
  localparam int RP_CYC    = RP_C0 < 1 ? 1 : RP_C0;
  localparam int RAS_C1    = RAS_C0 > (RC_C - RP_CYC) ? RAS_C0 : (RC_C - RP_CYC);
  localparam int RAS_CYC   = RAS_C1 > CHR_CYC ? RAS_C1 : CHR_CYC + 1;
  localparam int TMR_MAX   = PAUSE_CYC > RAS_CYC ? PAUSE_CYC : RAS_CYC;
  localparam int TW        = $clog2(TMR_MAX + 1);
  localparam int IW        = $clog2(REFI_CYC + 1);
  localparam int PW        = $clog2(BACKLOG_MAX + 1);
  localparam int NW        = $clog2(INIT_REFRESHES + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_CSR, S_RAS, S_PRE} state_t;

  state_t        state;
  logic [TW-1:0] tmr;
  logic [IW-1:0] ivl;
  logic [PW-1:0] pend;
  logic [NW-1:0] init_left;
  logic          tick, done, tmr_zero;

  assign tmr_zero = (tmr == '0);
  assign ready    = (init_left == '0) && (state != S_PAUSE);
  assign busy     = (state != S_IDLE);
  assign ref_req  = (state == S_IDLE) && ((init_left != '0) || (pend != '0));
  assign tick     = ready && (ivl == IW'(REFI_CYC - 1));
  assign done     = (state == S_RAS) && tmr_zero && (init_left == '0);
  assign ras_n    = (state != S_RAS);
  assign ucas_n   = !((state == S_CSR) || ((state == S_RAS) && (tmr > TW'(RAS_CYC - 1 - CHR_CYC))));
  assign lcas_n   = ucas_n;
  assign we_n     = 1'b1;
  assign dq_oe    = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_PAUSE;
      tmr       <= TW'(PAUSE_CYC - 1);
      init_left <= NW'(INIT_REFRESHES);
    end else begin
      unique case (state)
        S_PAUSE: if (tmr_zero) state <= S_IDLE; else tmr <= tmr - 1'b1;
        S_IDLE:  if (ref_req && ref_gnt) begin
                   state <= S_CSR;
                   tmr   <= TW'(CSR_CYC - 1);
                 end
        S_CSR:   if (tmr_zero) begin
                   state <= S_RAS;
                   tmr   <= TW'(RAS_CYC - 1);
                 end else tmr <= tmr - 1'b1;
        S_RAS:   if (tmr_zero) begin
                   state <= S_PRE;
                   tmr   <= TW'(RP_CYC - 1);
                   if (init_left != '0) init_left <= init_left - 1'b1;
                 end else tmr <= tmr - 1'b1;
        S_PRE:   if (tmr_zero) state <= S_IDLE; else tmr <= tmr - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl      <= '0;
      pend     <= '0;
      pend_ovf <= 1'b0;
    end else begin
      if (ready) ivl <= tick ? '0 : ivl + 1'b1;
      if (tick && !done) begin
        if (pend == PW'(BACKLOG_MAX)) pend_ovf <= 1'b1;
        else pend <= pend + 1'b1;
      end else if (done && !tick) begin
        pend <= pend - 1'b1;
      end
    end
  end

  p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!ucas_n && !lcas_n && ras_n));
  p_start_on_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ucas_n) && ras_n) |-> $past(ref_req && ref_gnt));
  p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && (RAS_CYC > 1)) |=> !ras_n);
  p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && (RP_CYC > 1)) |=> (ras_n && ucas_n));
  p_ready_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ovf |=> pend_ovf);
  p_no_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ref_req);
  p_strobe_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !ucas_n) |-> busy);
endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int CLK_NS  = 20;
  localparam int PAUSE   = (200000 + CLK_NS - 1) / CLK_NS;
  localparam int REFI    = 15600 / CLK_NS;
  localparam int CSR     = 1;
  localparam int CHR     = 1;
  localparam int RP      = 2;
  localparam int RASW    = 3;
  localparam int TOT     = CSR + RASW + RP;
  localparam int NINIT   = 8;
  localparam int BMAX    = 4;

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0;
  logic ref_req, busy, ready, ras_n, ucas_n, lcas_n, we_n, dq_oe, pend_ovf;

  dram_refresh_sched u_dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .busy(busy),
    .ready(ready), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n),
    .dq_oe(dq_oe), .pend_ovf(pend_ovf));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int m_pause = PAUSE, m_init = NINIT, m_pend = 0, m_seq = -1, m_ivl = 0;
  bit m_ovf = 1'b0;
  int falls = 0, init_falls = 0;
  bit prev_ras = 1'b1, ready_seen = 1'b0, done_sim = 1'b0;

  function automatic bit m_ready(); return m_init == 0 && m_pause == 0; endfunction
  function automatic bit m_busy();  return m_pause > 0 || m_seq >= 0; endfunction
  function automatic bit m_req();   return !m_busy() && (m_init > 0 || m_pend > 0); endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pause = PAUSE; m_init = NINIT; m_pend = 0; m_seq = -1; m_ivl = 0; m_ovf = 0;
    end else begin
      bit rdy, tk, dn, rq;
      rdy = m_ready();
      rq  = m_req();
      tk  = rdy && m_ivl == REFI - 1;
      dn  = m_seq == CSR + RASW - 1;
      if (rdy) m_ivl = tk ? 0 : m_ivl + 1;
      if (dn) begin
        if (m_init > 0) m_init--; else m_pend--;
      end
      if (tk) begin
        if (m_pend >= BMAX) m_ovf = 1; else m_pend++;
      end
      if (m_seq >= 0) m_seq = (m_seq == TOT - 1) ? -1 : m_seq + 1;
      else if (rq && ref_gnt) m_seq = 0;
      if (m_pause > 0) m_pause--;
    end
    if (cyc > 150000 && !done_sim) begin
      done_sim = 1;
      checks++; failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  always @(negedge clk) begin
    bit e_ras, e_cas;
    e_ras = !(m_seq >= CSR && m_seq < CSR + RASW);
    e_cas = !(m_seq >= 0 && m_seq < CSR + CHR);
    if (!rst_n) begin
      check(ras_n && ucas_n && lcas_n && !ready && !ref_req && !pend_ovf && busy,
            "R1", "reset state", {ras_n, ucas_n, lcas_n, ready, ref_req, pend_ovf, busy}, 7'b1110001);
    end else begin
      check(ras_n == e_ras, "R5", "ras_n", ras_n, e_ras);
      check(ucas_n == e_cas && lcas_n == e_cas, "R4", "cas_n", {ucas_n, lcas_n}, {e_cas, e_cas});
      check(ready == m_ready(), m_pause > 0 ? "R2" : "R3", "ready", ready, m_ready());
      check(ref_req == m_req(), m_ready() ? "R7" : "R6", "ref_req", ref_req, m_req());
      check(busy == m_busy(), "R11", "busy", busy, m_busy());
      check(pend_ovf == m_ovf, "R9", "pend_ovf", pend_ovf, m_ovf);
      check(we_n && !dq_oe, "R10", "we_n/dq_oe", {we_n, dq_oe}, 2'b10);
      if (prev_ras && !ras_n) begin
        falls++;
        if (!ready_seen) init_falls++;
      end
      if (ready && !ready_seen) begin
        ready_seen = 1;
        check(init_falls == NINIT, "R3", "warm-up refresh count", init_falls, NINIT);
      end
    end
    prev_ras = ras_n;
  end

  initial begin
    int f0, expn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ref_gnt = 1'b0;
    repeat (PAUSE + 50) @(negedge clk);
    check(falls == 0, "R6", "no refresh without grant", falls, 0);
    check(ref_req == 1'b1, "R6", "request waits", ref_req, 1);
    ref_gnt = 1'b1;
    wait (ready_seen);
    repeat (3 * REFI + 20) @(negedge clk);
    ref_gnt = 1'b0;
    repeat (3 * REFI + 10) @(negedge clk);
    expn = m_pend;
    check(expn >= 2, "R8", "backlog built", expn, 3);
    f0 = falls;
    ref_gnt = 1'b1;
    repeat (TOT * BMAX + 10) @(negedge clk);
    check(falls - f0 == expn, "R8", "backlog drained", falls - f0, expn);
    for (int i = 0; i < 2 * REFI; i++) begin
      ref_gnt = i[0];
      @(negedge clk);
    end
    ref_gnt = 1'b0;
    repeat (6 * REFI + 10) @(negedge clk);
    check(pend_ovf == 1'b1, "R9", "overflow raised", pend_ovf, 1);
    f0 = falls;
    ref_gnt = 1'b1;
    repeat (TOT * BMAX + 10) @(negedge clk);
    check(falls - f0 == BMAX, "R8", "saturated backlog served", falls - f0, BMAX);
    check(pend_ovf == 1'b1, "R9", "overflow sticky", pend_ovf, 1);
    repeat (REFI + 10) @(negedge clk);
    done_sim = 1;
    finish_run();
  end
endmodule